// File: doc/BRIEF.md
# Static Memory Chip-Select Strobe Timer

This block times single read and write transfers on an external static memory bus that has eight chip-select lines. Each chip-select line has its own configuration word. The word sets a wait-state count, a wait-state enable, a data-float time, the bus width, the byte-lane write style and the read strobe style. A requester offers a transfer on a valid/acknowledge port. The block then drives the selected chip select, the read strobe, one or two write-lane strobes, the address and the write data. On a read, it returns the captured data with a one-clock valid pulse.

The block clock runs at twice the bus cycle rate. An internal phase bit marks the two halves of each bus cycle, so one block clock is one half bus cycle. Every strobe length below is given in half cycles, which are block clocks. A transfer is accepted only in a clock where the phase bit is 0 and the bus is free. The first access clock is the next clock. Each access lasts a whole number of bus cycles.

Top module: `smc_strobe_gen`

## Requirements
- R1: Eight configuration words, indexed by `cfg_sel`, are written on a clock with `cfg_we` high and read back combinationally on `cfg_rdata`. The bit layout is: bits 6:0 wait count X, bit 7 wait enable, bits 11:8 float time F, bit 12 16-bit bus, bit 13 single 16-bit device, bit 14 early read. All words are zero after reset.
- R2: While the wait enable bit of a word is 0, its wait count field reads back as zero, whatever value was written.
- R3: The write strobe is low for 1 half cycle with waits disabled, and for 2X+2 half cycles with waits enabled. It starts one half cycle after the chip select falls.
- R4: In standard read mode (bit 14 = 0), the read strobe is low for 1 half cycle with waits disabled and for 2X+3 half cycles with waits enabled. It starts one half cycle after the chip select falls.
- R5: In early read mode, the read strobe is low for 2 half cycles with waits disabled and for 2X+4 half cycles with waits enabled. It starts together with the chip select.
- R6: Only the addressed chip select goes low. It stays low for 2 half cycles with waits disabled and for 2X+4 half cycles with waits enabled. The strobes are low only inside that window, and never both at once.
- R7: After a chip select rises, no chip select falls and no request is acknowledged for 2F half cycles. This holds for the same chip select as well as for the others.
- R8: Write lane strobes depend on the bus setting. On an 8-bit bus only lane 0 toggles. On a 16-bit bus with one 16-bit device, both lanes toggle together. On a 16-bit bus with two 8-bit devices, lane i toggles only if `req_be[i]` is 1.
- R9: Read data is sampled in the last low clock of the read strobe. `rd_valid` is high for exactly the next clock, with the sample on `rd_data`. On an 8-bit bus the upper byte is zero.
- R10: `req_ack` is high for one clock only, and only when `bus_phase` is 0 and the bus is free. `bus_phase` is 0 in the first clock after reset and alternates every clock. The transfer's timing comes from the configuration word as it stands at acknowledge; later writes to that word do not change the transfer already accepted.
- R11: While the chip select is low, `mem_addr` holds the request address. `mem_doe` is high only during a write. `mem_dout` carries the write data, with the upper byte zero on an 8-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word index |
| cfg_wdata | input | 15 | Configuration write data |
| cfg_rdata | output | 15 | Configuration read data for `cfg_sel` |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip select |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for split-lane writes |
| req_ack | output | 1 | Request accepted |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| bus_phase | output | 1 | Half-cycle phase bit |
| mem_cs_n | output | 8 | Chip selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 2 | Write lane strobes, active low |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 16 | Memory write data |
| mem_doe | output | 1 | Write data output enable |
| mem_din | input | 16 | Memory read data |

## Verification
The bench checks the strobe length at each edge of the wait setting: waits disabled, X = 0, X = 1 and X = 127. A design that mixed up the standard and early read offsets would show a read strobe one half cycle early or late. The bench also runs back-to-back requests across chip selects that have a non-zero float time. A design that ignored the float time would assert a chip select or return an acknowledge too early. The read data on `mem_din` changes every clock, so sampling one clock off returns a neighbouring value. Split-lane writes with each byte enable alone, plus a configuration write during an active access, expose a design that merges the lanes or reads its configuration live.

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NWS_W  = 7,
  parameter int TDF_W  = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int CFG_W = NWS_W + TDF_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_phase,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_rd_n,
  output logic [1:0]        mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);

  localparam int CNT_W   = NWS_W + 2;
  localparam int LANE_W  = DATA_W / 2;
  localparam int B_EN    = NWS_W;
  localparam int B_TDF   = NWS_W + 1;
  localparam int B_WIDE  = NWS_W + TDF_W + 1;
  localparam int B_BAT   = B_WIDE + 1;
  localparam int B_EARLY = B_WIDE + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_FLOAT} state_t;

  logic [CFG_W-1:0] cfg_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[g] <= '0;
      else if (cfg_we && cfg_sel == CS_W'(g)) cfg_q[g] <= cfg_wdata;
    end
  end

  logic [CFG_W-1:0] sel_cfg;
  assign sel_cfg   = cfg_q[cfg_sel];
  assign cfg_rdata = {sel_cfg[CFG_W-1:NWS_W], sel_cfg[B_EN] ? sel_cfg[NWS_W-1:0] : {NWS_W{1'b0}}};

  // timing of an incoming request, from its chip select's word
  logic [CFG_W-1:0] rq_cfg;
  logic [CNT_W-1:0] x2, rq_tlen, rq_slen, rq_send;
  logic             rq_ws, rq_early, rq_sbeg;
  assign rq_cfg   = cfg_q[req_cs];
  assign rq_ws    = rq_cfg[B_EN];
  assign rq_early = rq_cfg[B_EARLY] && !req_write;
  assign x2       = {1'b0, rq_cfg[NWS_W-1:0], 1'b0};
  assign rq_sbeg  = !rq_early;
  assign rq_tlen  = rq_ws ? x2 + CNT_W'(4) : CNT_W'(2);

  always_comb begin
    if (!rq_ws)         rq_slen = rq_early ? CNT_W'(2) : CNT_W'(1);
    else if (req_write) rq_slen = x2 + CNT_W'(2);
    else if (rq_early)  rq_slen = x2 + CNT_W'(4);
    else                rq_slen = x2 + CNT_W'(3);
  end
  assign rq_send = rq_slen + CNT_W'(rq_sbeg);

  state_t           st;
  logic             phase_q;
  logic [CNT_W-1:0] tcnt, a_send, a_tend, fl_end;
  logic             a_sbeg, a_wr, a_wide, a_bat;
  logic [TDF_W-1:0] a_tdf;
  logic [CS_W-1:0]  a_cs;
  logic [1:0]       a_be;
  logic [ADDR_W-1:0] a_addr;
  logic [DATA_W-1:0] a_wdata;

  assign fl_end    = CNT_W'({a_tdf, 1'b0});
  assign req_ack   = (st == ST_IDLE) && req_valid && !phase_q;
  assign bus_phase = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; phase_q <= 1'b0; tcnt <= '0;
      a_send <= '0; a_tend <= '0; a_sbeg <= 1'b0; a_wr <= 1'b0;
      a_wide <= 1'b0; a_bat <= 1'b0; a_tdf <= '0; a_cs <= '0;
      a_be <= '0; a_addr <= '0; a_wdata <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      phase_q  <= ~phase_q;
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_ack) begin
          st <= ST_ACC; tcnt <= '0;
          a_cs <= req_cs; a_wr <= req_write; a_addr <= req_addr;
          a_wdata <= req_wdata; a_be <= req_be;
          a_wide <= rq_cfg[B_WIDE]; a_bat <= rq_cfg[B_BAT];
          a_tdf <= rq_cfg[B_TDF +: TDF_W];
          a_sbeg <= rq_sbeg; a_send <= rq_send; a_tend <= rq_tlen;
        end
        ST_ACC: begin
          tcnt <= tcnt + 1'b1;
          if (!a_wr && tcnt == a_send - 1'b1) begin
            rd_data  <= a_wide ? mem_din : {{LANE_W{1'b0}}, mem_din[LANE_W-1:0]};
            rd_valid <= 1'b1;
          end
          if (tcnt == a_tend - 1'b1) begin
            tcnt <= '0;
            st   <= (a_tdf == '0) ? ST_IDLE : ST_FLOAT;
          end
        end
        ST_FLOAT: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == fl_end - 1'b1) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic in_acc, strobe_on, wr_on;
  assign in_acc    = (st == ST_ACC);
  assign strobe_on = in_acc && tcnt >= CNT_W'(a_sbeg) && tcnt < a_send;
  assign wr_on     = strobe_on && a_wr;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign mem_cs_n[g] = !(in_acc && a_cs == CS_W'(g));
  end

  assign mem_rd_n    = !(strobe_on && !a_wr);
  assign mem_wr_n[0] = !(wr_on && (!a_wide || a_bat || a_be[0]));
  assign mem_wr_n[1] = !(wr_on && a_wide && (a_bat || a_be[1]));
  assign mem_addr    = a_addr;
  assign mem_doe     = in_acc && a_wr;
  assign mem_dout    = a_wide ? a_wdata : {{LANE_W{1'b0}}, a_wdata[LANE_W-1:0]};

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_cs_n)); // R6
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || mem_wr_n != 2'b11) |-> (mem_cs_n != {NUM_CS{1'b1}})); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && mem_wr_n != 2'b11)); // R6
  AST_ACK_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (mem_cs_n == {NUM_CS{1'b1}})); // R7
  AST_ACK_ONCE: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack); // R10
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R9
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) bus_phase |=> !bus_phase); // R10

endmodule

// File: tb/smc_strobe_gen_tb.sv
module smc_strobe_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [14:0] cfg_wdata = '0;
  logic [14:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ack, rd_valid, bus_phase, mem_rd_n, mem_doe;
  logic [15:0] rd_data, mem_addr, mem_dout;
  logic [15:0] mem_din = '0;
  logic [7:0]  mem_cs_n;
  logic [1:0]  mem_wr_n;

  smc_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_phase(bus_phase), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  int din_n = 0;
  always @(negedge clk) begin
    din_n++;
    mem_din <= 16'(din_n * 16'h1357 + 16'h2468);
  end

  // reference model, time in half-cycle ticks since reset release
  logic [14:0] shadow [8];
  int tk = 0, acc_start = -100000, t_len = 0, s_beg = 0, s_len = 0, free_at = 0, rv_at = -1;
  int cs_m = 0;
  bit m_wr = 0, m_wide = 0, m_bat = 0;
  logic [1:0]  m_be = '0;
  logic [15:0] m_addr = '0, m_wdata = '0, rv_data = '0;

  initial for (int i = 0; i < 8; i++) shadow[i] = '0;

  function automatic logic [14:0] masked(input logic [14:0] w);
    return w[7] ? w : {w[14:7], 7'd0};
  endfunction

  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      bit cs_act, str, e_ack, e_ws, e_early;
      logic [7:0] e_cs;
      logic [1:0] e_wr;
      logic [14:0] w;
      int x;
      cs_act = tk >= acc_start && tk < acc_start + t_len;
      str    = tk >= acc_start + s_beg && tk < acc_start + s_beg + s_len;
      e_ack  = req_valid && tk >= free_at && (tk % 2 == 0);
      e_cs   = cs_act ? ~(8'd1 << cs_m) : 8'hFF;
      e_wr[0] = !(str && m_wr && (!m_wide || m_bat || m_be[0]));
      e_wr[1] = !(str && m_wr && m_wide && (m_bat || m_be[1]));
      check("R10 phase", {31'd0, bus_phase}, (tk % 2));
      check("R7 R10 ack", {31'd0, req_ack}, {31'd0, e_ack});
      check("R6 R7 cs", {24'd0, mem_cs_n}, {24'd0, e_cs});
      check("R4 R5 rd strobe", {31'd0, mem_rd_n}, {31'd0, !(str && !m_wr)});
      check("R3 R8 wr strobe", {30'd0, mem_wr_n}, {30'd0, e_wr});
      check("R9 rd_valid", {31'd0, rd_valid}, {31'd0, tk == rv_at});
      if (tk == rv_at) check("R9 rd_data", {16'd0, rd_data}, {16'd0, rv_data});
      check("R1 R2 cfg readback", {17'd0, cfg_rdata}, {17'd0, masked(shadow[cfg_sel])});
      check("R11 doe", {31'd0, mem_doe}, {31'd0, cs_act && m_wr});
      if (cs_act) begin
        check("R11 addr", {16'd0, mem_addr}, {16'd0, m_addr});
        if (m_wr) check("R11 dout", {16'd0, mem_dout}, {16'd0, m_wide ? m_wdata : {8'd0, m_wdata[7:0]}});
      end
      if (!m_wr && str && tk == acc_start + s_beg + s_len - 1) begin
        rv_data = m_wide ? mem_din : {8'd0, mem_din[7:0]};
        rv_at   = tk + 1;
      end
      if (e_ack) begin
        w = shadow[req_cs];
        x = int'(w[6:0]);
        e_ws = w[7];
        e_early = w[14] && !req_write;
        cs_m = int'(req_cs); m_wr = req_write; m_wide = w[12]; m_bat = w[13];
        m_be = req_be; m_addr = req_addr; m_wdata = req_wdata;
        acc_start = tk + 1;
        t_len = e_ws ? 2 * x + 4 : 2;
        s_beg = e_early ? 0 : 1;
        if (!e_ws)          s_len = e_early ? 2 : 1;
        else if (req_write) s_len = 2 * x + 2;
        else if (e_early)   s_len = 2 * x + 4;
        else                s_len = 2 * x + 3;
        free_at = acc_start + t_len + 2 * int'(w[11:8]);
      end
      if (cfg_we) shadow[cfg_sel] = cfg_wdata;
      tk++;
    end
  end

  task automatic cfg_wr(input int sel, input int nws, input bit en, input int tdf,
                        input bit wide, input bit bat, input bit early);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel);
    cfg_wdata = {early, bat, wide, 4'(tdf), en, 7'(nws)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input int cs, input bit wr, input logic [15:0] addr,
                      input logic [15:0] data, input logic [1:0] be);
    bit got = 0;
    req_valid = 1'b1; req_write = wr; req_cs = 3'(cs);
    req_addr = addr; req_wdata = data; req_be = be;
    while (!got) begin
      #3;
      if (req_ack) got = 1;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // reset state, R1 words zero
    for (int i = 0; i < 8; i++) begin
      cfg_sel = 3'(i); #1;
      check("R1 reset cfg", {17'd0, cfg_rdata}, 32'd0);
    end
    check("R6 reset cs", {24'd0, mem_cs_n}, 32'hFF);
    check("R3 reset wr", {30'd0, mem_wr_n}, 32'd3);
    check("R9 reset rd_valid", {31'd0, rd_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // waits disabled, 8-bit, standard
    cfg_wr(0, 9, 0, 0, 0, 0, 0);
    xfer(0, 1, 16'h0010, 16'hA55A, 2'b11);
    xfer(0, 0, 16'h0011, 16'h0, 2'b11);
    // R5: early read waits disabled, then X = 0 and X = 1
    cfg_wr(1, 0, 0, 1, 0, 0, 1);
    xfer(1, 0, 16'h0100, 16'h0, 2'b11);
    cfg_wr(1, 0, 1, 1, 1, 1, 1);
    xfer(1, 0, 16'h0101, 16'h0, 2'b11);
    xfer(1, 1, 16'h0102, 16'hBEEF, 2'b11);
    cfg_wr(1, 1, 1, 0, 1, 1, 1);
    xfer(1, 0, 16'h0103, 16'h0, 2'b11);
    // R8 split lanes, standard read, float 2
    cfg_wr(2, 3, 1, 2, 1, 0, 0);
    xfer(2, 1, 16'h0200, 16'h1234, 2'b01);
    xfer(2, 1, 16'h0201, 16'h5678, 2'b10);
    xfer(2, 0, 16'h0202, 16'h0, 2'b11);
    // R7 back to back across selects with float 15
    cfg_wr(6, 1, 1, 15, 1, 1, 0);
    xfer(6, 0, 16'h0600, 16'h0, 2'b11);
    xfer(0, 1, 16'h0601, 16'h00C3, 2'b11);
    xfer(6, 1, 16'h0602, 16'h3C3C, 2'b11);
    xfer(6, 1, 16'h0603, 16'h4C4C, 2'b11);
    // longest strobe, X = 127
    cfg_wr(3, 127, 1, 0, 1, 1, 1);
    xfer(3, 0, 16'h0300, 16'h0, 2'b11);
    cfg_wr(3, 127, 1, 0, 1, 1, 0);
    xfer(3, 1, 16'h0301, 16'hFACE, 2'b11);
    xfer(3, 0, 16'h0302, 16'h0, 2'b11);
    // R2 count reads zero when disabled
    cfg_wr(4, 5, 0, 3, 1, 0, 1);
    cfg_sel = 3'd4; #1;
    check("R2 nws masked", {25'd0, cfg_rdata[6:0]}, 32'd0);
    check("R2 other fields", {28'd0, cfg_rdata[11:8]}, 32'd3);
    // R10 config change during an active access is not seen
    cfg_wr(5, 4, 1, 1, 1, 1, 0);
    xfer(5, 0, 16'h0500, 16'h0, 2'b11);
    cfg_wr(5, 0, 0, 0, 0, 0, 1);
    repeat (40) @(negedge clk);
    xfer(5, 0, 16'h0501, 16'h0, 2'b11);
    repeat (40) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule